// File: doc/BRIEF.md
# Page Load Buffer with Timeout

This block stages the write data for one page program operation. After a command decoder has recognised a program request, it pulses `arm`. That opens a load window. Each word then arrives as a low pulse on `ce_n` while `oe_n` is held high. The block samples the word's address when it sees `ce_n` fall, and it takes the data word when it sees `ce_n` rise. The upper address bits name the page. The low `SLOT_AW` bits pick one of the slots in that page. Loads may come in any order, and loading the same slot again replaces the word held there.

There is no end command. The window closes on inactivity: if no accepted load begins within `IDLE_MAX` clock cycles of the last stored word (or of `arm`), the window shuts. At that moment a one-cycle `commit` pulse hands the whole page image and its page number to the program engine. Slots that were never loaded appear in that image as all-ones, the erased value.

Some loads are refused. A load aimed at a different page than the first one is dropped and flagged. A load that begins too long after the previous word is also dropped and flagged. The control inputs `ce_n` and `oe_n` are expected to be synchronous to `clk` already; the block compares each one with its value at the previous edge.

Top module: `page_load_buf`

## Requirements
- R1: After reset the window is closed. `commit`, `page_err` and `late_err` are 0, and every slot of `commit_data` reads all-ones.
- R2: A sampled `arm` opens the window, clears every slot to the erased state and clears both error flags, whatever state the block was in.
- R3: The slot and page of a load come from `addr` at the edge where `ce_n` is first seen low. The stored word is `din` at the edge where `ce_n` is first seen high again. The values on `addr` and `din` at other times have no effect.
- R4: Slots may be loaded in any order. A slot loaded twice in one window holds the later word.
- R5: At commit, every slot not loaded in the current window reads as all-ones.
- R6: A `ce_n` low pulse that starts while `oe_n` is low is ignored. It stores nothing, and it neither restarts nor pauses the inactivity timer.
- R7: The first accepted load fixes the page. A later load whose page field (`addr[ADDR_W-1:SLOT_AW]`) differs from it is discarded, and `page_err` is set. It stays set until the next `arm`. A discarded load does not restart the timer.
- R8: After at least one word has been stored, a load is discarded and `late_err` is set (until the next `arm`) if its falling edge is sampled more than `GAP_MAX` clock edges after the edge that sampled the previous rising edge. This limit does not apply to the first load after `arm`.
- R9: If no load is accepted, the window closes at the `IDLE_MAX`-th clock edge after the edge that sampled the last stored word's rising edge (or `arm`). `commit` is high for exactly the one cycle following that edge, and `win_open` falls in the same cycle.
- R10: While `commit` is high, `commit_page` equals the page field of the first accepted load, and slot i of the page is `commit_data[i*WORD_W +: WORD_W]`.
- R11: A window that closes with no word stored produces no `commit` pulse.
- R12: Load pulses while the window is closed are ignored and leave nothing in the next window's page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm | input | 1 | Opens a new load window |
| ce_n | input | 1 | Active-low load strobe (synchronous) |
| oe_n | input | 1 | Active-low output enable; must be high for a load |
| addr | input | ADDR_W | Load address: page field above `SLOT_AW`, slot below |
| din | input | WORD_W | Load data word |
| win_open | output | 1 | Load window is open |
| page_err | output | 1 | A load to a foreign page was discarded |
| late_err | output | 1 | A load that started too late was discarded |
| commit | output | 1 | One-cycle pulse: page image is ready |
| commit_page | output | ADDR_W-SLOT_AW | Page number of the committed image |
| commit_data | output | (1<<SLOT_AW)*WORD_W | Page image, slot i at bits i*WORD_W upward |

## Verification
The timing corner cases are covered by counting cycles from the edge that stored a word. A timer counting one cycle off would move the `commit` pulse by one cycle. A load started exactly `GAP_MAX` edges after the previous word must be accepted, and one started a cycle later must be refused; a comparator using the wrong bound would accept or refuse the wrong one. The bench also sends pulses with `oe_n` low and pulses to a foreign page. It checks two things: that these pulses leave no word in the page, and that they do not move the commit cycle. A design that let such a pulse restart the timer would commit late. The bench also changes `addr` and `din` inside each pulse, re-opens a window after a full page, and lets a window lapse with no load. A design that latched at the wrong edge, kept stale slots or committed an empty page would show up there.

// File: rtl/pld_pkg.sv
package pld_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_OPEN = 2'd1,
    ST_LOAD = 2'd2
  } pld_state_e;
endpackage

// File: rtl/pld_edge_det.sv
// Registers the strobe and reports its two edges, qualified for a load.
module pld_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic oe_n,
  output logic fall_ok,
  output logic rise
);
  logic ce_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ce_q <= 1'b1;
    else        ce_q <= ce_n;
  end

  assign fall_ok = ce_q & ~ce_n & oe_n;
  assign rise    = ~ce_q & ce_n;
endmodule

// File: rtl/pld_gap_timer.sv
// Counts edges since the last restart; reports the gap limit and expiry.
module pld_gap_timer #(
  parameter int GAP_MAX  = 3000,
  parameter int IDLE_MAX = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic late,
  output logic expire
);
  localparam int CW = $clog2(IDLE_MAX + 1);
  localparam logic [CW-1:0] GAP_L = CW'(GAP_MAX);
  localparam logic [CW-1:0] END_L = CW'(IDLE_MAX - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (restart)        cnt_q <= '0;
    else if (run && !expire) cnt_q <= cnt_q + 1'b1;
  end

  assign late   = (cnt_q >= GAP_L);
  assign expire = (cnt_q == END_L);
endmodule

// File: rtl/pld_slot_store.sv
// One word register and one valid bit per slot; unloaded slots read erased.
module pld_slot_store #(
  parameter int WORD_W  = 16,
  parameter int SLOT_AW = 6
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              clear,
  input  logic                              wr,
  input  logic [SLOT_AW-1:0]                wr_slot,
  input  logic [WORD_W-1:0]                 wr_data,
  output logic [(1<<SLOT_AW)*WORD_W-1:0]    page_data
);
  localparam int SLOTS = 1 << SLOT_AW;

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic              vld_q;
    logic [WORD_W-1:0] word_q;
    logic              hit;

    assign hit = wr && (wr_slot == SLOT_AW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     vld_q <= 1'b0;
      else if (clear) vld_q <= 1'b0;
      else if (hit)   vld_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (hit) word_q <= wr_data;
    end

    assign page_data[i*WORD_W +: WORD_W] = vld_q ? word_q : {WORD_W{1'b1}};
  end
endmodule

// File: rtl/page_load_buf.sv
module page_load_buf
  import pld_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int WORD_W   = 16,
  parameter int SLOT_AW  = 6,
  parameter int GAP_MAX  = 3000,
  parameter int IDLE_MAX = 10000
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                arm,
  input  logic                                ce_n,
  input  logic                                oe_n,
  input  logic [ADDR_W-1:0]                   addr,
  input  logic [WORD_W-1:0]                   din,
  output logic                                win_open,
  output logic                                page_err,
  output logic                                late_err,
  output logic                                commit,
  output logic [ADDR_W-SLOT_AW-1:0]           commit_page,
  output logic [(1<<SLOT_AW)*WORD_W-1:0]      commit_data
);
  localparam int PAGE_W = ADDR_W - SLOT_AW;

  function automatic logic [PAGE_W-1:0] page_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:SLOT_AW];
  endfunction

  function automatic logic [SLOT_AW-1:0] slot_of(input logic [ADDR_W-1:0] a);
    return a[SLOT_AW-1:0];
  endfunction

  pld_state_e        state_q;
  logic              got_first_q;
  logic [PAGE_W-1:0] page_q;
  logic [SLOT_AW-1:0] slot_q;
  logic              page_err_q, late_err_q, commit_q;

  // named internal events
  logic ev_fall_ok, ev_rise;
  logic tmr_late, tmr_expire;
  logic in_open, page_hit;
  logic ev_accept, ev_rej_page, ev_rej_late, ev_store, ev_timeout, ev_commit;

  pld_edge_det u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce_n    (ce_n),
    .oe_n    (oe_n),
    .fall_ok (ev_fall_ok),
    .rise    (ev_rise)
  );

  assign in_open  = (state_q == ST_OPEN);
  assign page_hit = !got_first_q || (page_of(addr) == page_q);

  assign ev_accept   = in_open && ev_fall_ok && page_hit && !(got_first_q && tmr_late) && !arm;
  assign ev_rej_page = in_open && ev_fall_ok && !page_hit && !arm;
  assign ev_rej_late = in_open && ev_fall_ok && page_hit && got_first_q && tmr_late && !arm;
  assign ev_store    = (state_q == ST_LOAD) && ev_rise && !arm;
  assign ev_timeout  = in_open && tmr_expire && !ev_accept && !arm;
  assign ev_commit   = ev_timeout && got_first_q;

  pld_gap_timer #(
    .GAP_MAX  (GAP_MAX),
    .IDLE_MAX (IDLE_MAX)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (arm || ev_store),
    .run     (in_open),
    .late    (tmr_late),
    .expire  (tmr_expire)
  );

  pld_slot_store #(
    .WORD_W  (WORD_W),
    .SLOT_AW (SLOT_AW)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (arm),
    .wr        (ev_store),
    .wr_slot   (slot_q),
    .wr_data   (din),
    .page_data (commit_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      got_first_q <= 1'b0;
      page_q      <= '0;
      slot_q      <= '0;
      page_err_q  <= 1'b0;
      late_err_q  <= 1'b0;
      commit_q    <= 1'b0;
    end else begin
      commit_q <= ev_commit;
      if (arm) begin
        state_q     <= ST_OPEN;
        got_first_q <= 1'b0;
        page_err_q  <= 1'b0;
        late_err_q  <= 1'b0;
      end else begin
        if (ev_rej_page) page_err_q <= 1'b1;
        if (ev_rej_late) late_err_q <= 1'b1;
        unique case (state_q)
          ST_OPEN: begin
            if (ev_accept) begin
              state_q     <= ST_LOAD;
              slot_q      <= slot_of(addr);
              got_first_q <= 1'b1;
              if (!got_first_q) page_q <= page_of(addr);
            end else if (ev_timeout) begin
              state_q <= ST_IDLE;
            end
          end
          ST_LOAD: if (ev_store) state_q <= ST_OPEN;
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign win_open    = (state_q != ST_IDLE);
  assign page_err    = page_err_q;
  assign late_err    = late_err_q;
  assign commit      = commit_q;
  assign commit_page = page_q;
endmodule

// File: rtl/pld_chk.sv
module pld_chk (
  input logic clk,
  input logic rst_n,
  input logic arm,
  input logic ce_n,
  input logic oe_n,
  input logic win_open,
  input logic commit,
  input logic page_err,
  input logic late_err,
  input logic ev_accept,
  input logic ev_store,
  input logic ev_rej_page,
  input logic ev_rej_late
);
  a_r9_commit_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);

  a_r9_close_at_commit: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !win_open);

  a_r11_commit_from_open: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $past(win_open));

  a_r2_arm_fresh: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (win_open && !page_err && !late_err && !commit));

  a_r12_closed_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_open && !arm) |=> !win_open);

  a_r6_accept_oe_high: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |-> (oe_n && !ce_n && win_open));

  a_r3_store_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    ev_store |-> ce_n);

  a_r7_page_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(page_err) |-> $past(ev_rej_page));

  a_r8_late_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(late_err) |-> $past(ev_rej_late));
endmodule

bind page_load_buf pld_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .arm         (arm),
  .ce_n        (ce_n),
  .oe_n        (oe_n),
  .win_open    (win_open),
  .commit      (commit),
  .page_err    (page_err),
  .late_err    (late_err),
  .ev_accept   (ev_accept),
  .ev_store    (ev_store),
  .ev_rej_page (ev_rej_page),
  .ev_rej_late (ev_rej_late)
);

// File: tb/page_load_buf_tb_top.sv
`timescale 1ns/1ps
module page_load_buf_tb_top;
  localparam int AW = 20;
  localparam int WW = 16;
  localparam int SAW = 6;
  localparam int NS = 1 << SAW;
  localparam int GM = 20;
  localparam int IM = 50;
  localparam int PW = AW - SAW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm = 1'b0;
  logic ce_n = 1'b1;
  logic oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [WW-1:0] din = '0;
  logic win_open, page_err, late_err, commit;
  logic [PW-1:0] commit_page;
  logic [NS*WW-1:0] commit_data;

  int checks = 0;
  int errors = 0;
  logic [WW-1:0] exp_mem [NS];

  always #5 clk = ~clk;

  page_load_buf #(
    .ADDR_W(AW), .WORD_W(WW), .SLOT_AW(SAW), .GAP_MAX(GM), .IDLE_MAX(IM)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .arm(arm), .ce_n(ce_n), .oe_n(oe_n),
    .addr(addr), .din(din), .win_open(win_open), .page_err(page_err),
    .late_err(late_err), .commit(commit), .commit_page(commit_page),
    .commit_data(commit_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic exp_clear();
    for (int i = 0; i < NS; i++) exp_mem[i] = '1;
  endtask

  task automatic check_page(input string tag);
    int bad = 0;
    int first = -1;
    for (int i = 0; i < NS; i++)
      if (commit_data[i*WW +: WW] !== exp_mem[i]) begin
        bad++;
        if (first < 0) first = i;
      end
    if (first < 0) chk(1'b1, tag, 0, 0);
    else chk(1'b0, {tag, " slot word"}, 64'(commit_data[first*WW +: WW]), 64'(exp_mem[first]));
  endtask

  task automatic arm_win(input string tag);
    @(negedge clk); arm = 1'b1;
    @(negedge clk); arm = 1'b0;
    chk(win_open === 1'b1, {tag, " R2 win_open"}, 64'(win_open), 1);
    chk(page_err === 1'b0 && late_err === 1'b0, {tag, " R2 errors cleared"},
        64'({page_err, late_err}), 0);
    exp_clear();
  endtask

  // gap negedges, then ce low for two cycles; addr/din changed mid-pulse (R3)
  task automatic pulse(input int gap, input logic oe, input logic [AW-1:0] a, input logic [WW-1:0] d);
    repeat (gap) @(negedge clk);
    addr = a; oe_n = oe; ce_n = 1'b0; din = 16'hDEAD;
    @(negedge clk);
    addr = ~a; din = d;
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic wait_commit(input int exp_cnt, input logic [PW-1:0] pg, input string tag);
    int seen = -1;
    bit extra = 0;
    for (int i = 1; i <= IM + 8; i++) begin
      @(negedge clk);
      if (commit === 1'b1) begin
        if (seen < 0) begin
          seen = i;
          chk(win_open === 1'b0, {tag, " R9 window closed at commit"}, 64'(win_open), 0);
          chk(commit_page === pg, {tag, " R10 commit_page"}, 64'(commit_page), 64'(pg));
          check_page({tag, " R5 page image"});
        end else extra = 1;
      end
    end
    chk(seen == exp_cnt, {tag, " R9 commit cycle"}, 64'(seen), 64'(exp_cnt));
    chk(!extra, {tag, " R9 single-cycle commit"}, 64'(extra), 0);
  endtask

  task automatic t_reset();
    chk(win_open === 1'b0 && commit === 1'b0, "R1 closed after reset", 64'({win_open, commit}), 0);
    chk(page_err === 1'b0 && late_err === 1'b0, "R1 errors after reset", 64'({page_err, late_err}), 0);
    chk(commit_data === '1, "R1 slots erased after reset", 64'(commit_data[63:0]), 64'hFFFF_FFFF_FFFF_FFFF);
  endtask

  task automatic t_basic();
    logic [PW-1:0] p = 14'h2A5;
    arm_win("basic");
    pulse(2, 1'b1, {p, 6'd5}, 16'h1111); exp_mem[5] = 16'h1111;
    pulse(3, 1'b1, {p, 6'd0}, 16'h2222); exp_mem[0] = 16'h2222;
    pulse(1, 1'b1, {p, 6'd63}, 16'h3333); exp_mem[63] = 16'h3333;
    pulse(2, 1'b1, {p, 6'd5}, 16'h5555); exp_mem[5] = 16'h5555; // R4 rewrite
    wait_commit(IM + 1, p, "basic R4");
  endtask

  task automatic t_oe_low();
    logic [PW-1:0] q = 14'h0013;
    arm_win("oe");
    pulse(2, 1'b1, {q, 6'd10}, 16'hA0A0); exp_mem[10] = 16'hA0A0;
    pulse(4, 1'b0, {q, 6'd7}, 16'h0707); // R6 ignored
    wait_commit(IM + 1 - 6, q, "oe R6");
  endtask

  task automatic t_page();
    logic [PW-1:0] p2 = 14'h1234;
    arm_win("page");
    pulse(2, 1'b1, {p2, 6'd1}, 16'h0101); exp_mem[1] = 16'h0101;
    chk(page_err === 1'b0, "R7 no error on first page", 64'(page_err), 0);
    pulse(2, 1'b1, {14'h1235, 6'd2}, 16'h0202);
    chk(page_err === 1'b1, "R7 foreign page flagged", 64'(page_err), 1);
    wait_commit(IM + 1 - 4, p2, "page R7");
  endtask

  task automatic t_late();
    logic [PW-1:0] p4 = 14'h3FFF;
    arm_win("late");
    pulse(GM + 5, 1'b1, {p4, 6'd3}, 16'h0303); exp_mem[3] = 16'h0303;
    chk(late_err === 1'b0, "R8 first load exempt from gap limit", 64'(late_err), 0);
    pulse(GM, 1'b1, {p4, 6'd4}, 16'h0404); exp_mem[4] = 16'h0404;
    chk(late_err === 1'b0, "R8 load at gap limit accepted", 64'(late_err), 0);
    pulse(GM + 1, 1'b1, {p4, 6'd8}, 16'h0808);
    chk(late_err === 1'b1, "R8 load past gap limit flagged", 64'(late_err), 1);
    wait_commit(IM + 1 - (GM + 3), p4, "late R8");
  endtask

  task automatic t_empty();
    int closed = -1;
    bit any_commit = 0;
    arm_win("empty");
    for (int i = 1; i <= IM + 5; i++) begin
      @(negedge clk);
      if (commit === 1'b1) any_commit = 1;
      if (win_open === 1'b0 && closed < 0) closed = i;
    end
    chk(closed == IM, "R11 empty window closes on timeout", 64'(closed), 64'(IM));
    chk(!any_commit, "R11 no commit for empty window", 64'(any_commit), 0);
  endtask

  task automatic t_outside();
    logic [PW-1:0] p5 = 14'h0A0A;
    bit moved = 0;
    pulse(2, 1'b1, {p5, 6'd9}, 16'h0909);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (win_open !== 1'b0 || commit !== 1'b0) moved = 1;
    end
    chk(!moved, "R12 closed window ignores loads", 64'(moved), 0);
    arm_win("outside");
    pulse(2, 1'b1, {p5, 6'd0}, 16'h0F0F); exp_mem[0] = 16'h0F0F;
    wait_commit(IM + 1, p5, "outside R12");
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_oe_low();
    t_page();
    t_late();
    t_empty();
    t_outside();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule